// File: doc/BRIEF.md
# Phase-Synchronized 8-bit Timer with Prescaler

This block is the free-running counter of a small processor core. The core runs each instruction cycle as four phases, Q1 to Q4. The block is clocked once per phase, and the core reports the current phase on a two-bit input. The counter can count instruction cycles. It can also count edges from an outside source, which is either a dedicated pin or a comparator output. A power-of-two prescaler can sit in the count path.

Software loads the counter through a write port and reads it continuously. A load freezes counting for two instruction cycles and restarts the prescaler. External edges never reach the counter directly. They pass through the prescaler tap or straight through, and are then sampled on only two of the four phases. Pulses that are too short are therefore not counted. A six-bit option word selects the source, the active edge, whether the prescaler is used, and the ratio.

Top module: `cyc_timer`

## Requirements
- R1: When `cnt_we` is high at a clock edge, `cnt_q` shows `cnt_wd` after that edge. A write wins over a same-edge increment, and it clears the prescaler count.
- R2: After a write at a Q4 edge (phase code 3), the next two Q4 edges leave the counter unchanged. Counting resumes at the third Q4 edge.
- R3: With option bit 5 = 0 and bit 3 = 1 (internal source, no prescaler), the counter increments by one at every Q4 edge and at no edge of any other phase.
- R4: With option bit 5 = 0, bit 3 = 0 and bits 2:0 = k, the counter advances once per 2^(k+1) instruction cycles. After a write, the first advance lands on Q4 edge number 2 + 2^(k+1).
- R5: With option bit 5 = 1 and bit 3 = 1, the source level is sampled only at edges whose phase code is 1 or 3 (Q2, Q4).
  - A 0-to-1 change between consecutive samples adds one to the counter, on the clock edge after that sample.
  - A high level that spans no sampling edge is not counted.
- R6: Option bit 4 = 1 makes the falling edge of the selected source the counted edge. Bit 4 = 0 selects the rising edge.
- R7: With `cmp_sel` = 1 the source is `cmp_in` and `pin_in` has no effect. With `cmp_sel` = 0 the roles swap.
- R8: With option bit 5 = 1, bit 3 = 0 and bits 2:0 = k, each clock-detected active edge advances the prescaler.
  - The prescaler's symmetric output, which divides by 2^(k+1), is what the Q2/Q4 sampling sees.
  - An input that is high for one clock and low for one clock is still counted at the divided rate.
- R9: An increment from 0xFF gives 0x00 and raises `ovf_o` for exactly one clock, in the clock where `cnt_q` first reads 0x00. A write never raises `ovf_o`.
- R10: Reset behaves as follows:
  - It sets the option word to all ones: external source, falling edge, prescaler off.
  - It leaves the counter value unchanged.
  - It holds `ovf_o` low.
- R11: `pin_force_in` equals option bit 5, so selecting the external source forces the pin to act as an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one edge per phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | input | 2 | Current phase: 0=Q1, 1=Q2, 2=Q3, 3=Q4 |
| cnt_we | input | 1 | Counter load strobe |
| cnt_wd | input | 8 | Counter load value |
| cnt_q | output | 8 | Counter value |
| opt_we | input | 1 | Option word load strobe |
| opt_wd | input | 6 | Option word: [5] external, [4] falling edge, [3] prescaler off, [2:0] ratio |
| pin_in | input | 1 | External count pin |
| cmp_in | input | 1 | Comparator output used as count source |
| cmp_sel | input | 1 | 1 selects the comparator as the external source |
| pin_force_in | output | 1 | High when the pin direction must be forced to input |
| ovf_o | output | 1 | One-clock wrap pulse |

## Verification
The bench builds the block with its default parameters:
- an 8-bit counter;
- a two-instruction-cycle hold;
- the prescaler generated.

With these values every ratio from 1:2 to 1:256 can be reached within a few thousand clocks. The bench sweeps all eight ratios and checks the exact advance edge for each.

The two-phase sampling rule is exercised at the clock level. Single-clock pulses are placed at Q1/Q3 edges, and two-clock pulses straddle a sampling edge. Both kinds are also pushed through the prescaler, where the narrow pulses must still count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // phase codes reported by the core
   typedef enum logic [1:0] {PH_Q1 = 2'd0, PH_Q2 = 2'd1, PH_Q3 = 2'd2, PH_Q4 = 2'd3} phase_e;

   localparam int RATIO_W = 3;
   localparam int PRE_W   = 2 ** RATIO_W;
   localparam int OPT_W   = 3 + RATIO_W;

   typedef struct packed {
      logic               src_ext;
      logic               fall_edge;
      logic               pre_off;
      logic [RATIO_W-1:0] ratio;
   } opt_t;
endpackage

// File: rtl/tmr_presc.sv
module tmr_presc #(
   parameter int PW    = 8,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [SEL_W-1:0] sel,
   output logic             tap,
   output logic             full
);
   if (PW != 2 ** SEL_W) begin : g_bad_width
      $error("tmr_presc: PW must equal 2**SEL_W");
   end

   logic [PW-1:0] pcnt;
   logic [PW-1:0] mask;

   always_comb begin
      mask = (PW'(2) << sel) - PW'(1);
      tap  = pcnt[sel];
      full = (pcnt & mask) == mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pcnt <= '0;
      else if (clr) pcnt <= '0;
      else if (adv) pcnt <= pcnt + PW'(1);
   end
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
   parameter logic [1:0] SAMP_A = 2'd1,
   parameter logic [1:0] SAMP_B = 2'd3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] phase,
   input  logic       pin_in,
   input  logic       cmp_in,
   input  logic       cmp_sel,
   input  logic       fall_edge,
   input  logic       path,
   output logic       src,
   output logic       rise,
   output logic       tick
);
   if (SAMP_A == SAMP_B) begin : g_bad_phase
      $error("tmr_edge_sync: sampling phases must differ");
   end

   logic raw_d;
   logic samp;
   logic samp_now;

   always_comb begin
      src      = (cmp_sel ? cmp_in : pin_in) ^ fall_edge;
      rise     = src & ~raw_d;
      samp_now = (phase == SAMP_A) || (phase == SAMP_B);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_d <= 1'b0;
         samp  <= 1'b0;
         tick  <= 1'b0;
      end else begin
         raw_d <= src;
         if (samp_now) begin
            tick <= path & ~samp;
            samp <= path;
         end else begin
            tick <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tmr_hold.sv
module tmr_hold #(
   parameter int         HOLD_CYC = 2,
   parameter logic [1:0] DEC_PH   = 2'd3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] phase,
   input  logic       load,
   output logic       busy
);
   localparam int HW = $clog2(HOLD_CYC + 1);

   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("tmr_hold: HOLD_CYC must be at least 1");
   end

   logic [HW-1:0] inh;

   assign busy = inh != '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        inh <= '0;
      else if (load)                     inh <= HW'(HOLD_CYC);
      else if (busy && phase == DEC_PH)  inh <= inh - HW'(1);
   end
endmodule

// File: rtl/cyc_timer.sv
module cyc_timer
   import tmr_pkg::*;
#(
   parameter int         CNT_W    = 8,
   parameter int         HOLD_CYC = 2,
   parameter bit         PRESC_EN = 1'b1,
   parameter logic [1:0] COUNT_PH = 2'd3,
   parameter logic [1:0] SAMP_A   = 2'd1,
   parameter logic [1:0] SAMP_B   = 2'd3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       phase,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wd,
   output logic [CNT_W-1:0] cnt_q,
   input  logic             opt_we,
   input  logic [OPT_W-1:0] opt_wd,
   input  logic             pin_in,
   input  logic             cmp_in,
   input  logic             cmp_sel,
   output logic             pin_force_in,
   output logic             ovf_o
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("cyc_timer: CNT_W must be at least 2");
   end

   opt_t             opt_q;
   logic [CNT_W-1:0] cnt;
   logic             opt_ext;
   logic             hold_busy;
   logic             eff_pre_off;
   logic             q4;
   logic             src, rise, tick, path;
   logic             tap, full;
   logic             presc_adv, presc_clr;
   logic             inc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      opt_q <= '1;
      else if (opt_we) opt_q <= opt_t'(opt_wd);
   end

   assign opt_ext      = opt_q.src_ext;
   assign pin_force_in = opt_q.src_ext;
   assign q4           = phase == COUNT_PH;
   assign eff_pre_off  = opt_q.pre_off | ~PRESC_EN;
   assign presc_clr    = cnt_we | opt_we;
   assign presc_adv    = ~eff_pre_off & (opt_ext ? rise : (q4 & ~hold_busy));
   assign path         = eff_pre_off ? src : tap;
   assign inc          = ~hold_busy & (opt_ext ? tick : (q4 & (eff_pre_off | full)));

   tmr_hold #(.HOLD_CYC(HOLD_CYC), .DEC_PH(COUNT_PH)) hold_i (
      .clk(clk), .rst_n(rst_n), .phase(phase), .load(cnt_we), .busy(hold_busy)
   );

   tmr_edge_sync #(.SAMP_A(SAMP_A), .SAMP_B(SAMP_B)) sync_i (
      .clk(clk), .rst_n(rst_n), .phase(phase), .pin_in(pin_in), .cmp_in(cmp_in),
      .cmp_sel(cmp_sel), .fall_edge(opt_q.fall_edge), .path(path),
      .src(src), .rise(rise), .tick(tick)
   );

   if (PRESC_EN) begin : g_presc
      tmr_presc #(.PW(PRE_W), .SEL_W(RATIO_W)) presc_i (
         .clk(clk), .rst_n(rst_n), .clr(presc_clr), .adv(presc_adv),
         .sel(opt_q.ratio), .tap(tap), .full(full)
      );
   end else begin : g_no_presc
      assign tap  = 1'b0;
      assign full = 1'b1;
   end

   // counter keeps its value across reset
   always_ff @(posedge clk) begin
      if (cnt_we)   cnt <= cnt_wd;
      else if (inc) cnt <= cnt + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovf_o <= 1'b0;
      else        ovf_o <= ~cnt_we & inc & (cnt == '1);
   end

   assign cnt_q = cnt;
endmodule

// File: rtl/cyc_timer_chk.sv
module cyc_timer_chk #(
   parameter int         CNT_W    = 8,
   parameter logic [1:0] COUNT_PH = 2'd3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       phase,
   input logic             cnt_we,
   input logic [CNT_W-1:0] cnt_wd,
   input logic             opt_we,
   input logic             opt_ext,
   input logic             hold_busy,
   input logic [CNT_W-1:0] cnt_q,
   input logic             ovf_o
);
   // R1
   load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> cnt_q == $past(cnt_wd));

   // R2
   hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_busy && !cnt_we) |=> $stable(cnt_q));

   // R3
   q4_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_we && !opt_we && !opt_ext && phase != COUNT_PH) |=> $stable(cnt_q));

   // R5
   single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_we |=> (cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));

   // R9
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> cnt_q == '0);

   // R9
   wrap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> !ovf_o);
endmodule

bind cyc_timer cyc_timer_chk #(.CNT_W(CNT_W), .COUNT_PH(COUNT_PH)) chk_i (
   .clk(clk), .rst_n(rst_n), .phase(phase), .cnt_we(cnt_we), .cnt_wd(cnt_wd),
   .opt_we(opt_we), .opt_ext(opt_ext), .hold_busy(hold_busy),
   .cnt_q(cnt_q), .ovf_o(ovf_o)
);

// File: tb/cyc_timer_tb.sv
module cyc_timer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] ph;
   logic       wr_en;
   logic [7:0] wr_data;
   logic       opt_we;
   logic [5:0] opt_wd;
   logic       pin, cmp, csel;
   logic [7:0] cnt;
   logic       ovf, force_in;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   cyc_timer dut_i (
      .clk(clk), .rst_n(rst_n), .phase(ph), .cnt_we(wr_en), .cnt_wd(wr_data),
      .cnt_q(cnt), .opt_we(opt_we), .opt_wd(opt_wd), .pin_in(pin), .cmp_in(cmp),
      .cmp_sel(csel), .pin_force_in(force_in), .ovf_o(ovf)
   );

   // behavioural reference
   int m_cnt, m_inh, m_pcnt, m_samp, m_rawd, m_tick, m_ovf, m_opt;
   bit m_valid = 1'b0;
   int s_src, s_r, s_pre, s_ext, s_inc, s_npc, s_ntick, s_nsamp, s_path;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_opt = 63; m_inh = 0; m_pcnt = 0; m_samp = 0; m_rawd = 0; m_tick = 0; m_ovf = 0;
      end else begin
         s_src = int'(csel ? cmp : pin) ^ ((m_opt >> 4) & 1);
         s_r   = m_opt & 7;
         s_pre = ((m_opt >> 3) & 1) == 0;
         s_ext = (m_opt >> 5) & 1;
         s_inc = 0; s_npc = m_pcnt; s_ntick = 0; s_nsamp = m_samp;
         if (s_ext == 0) begin
            if (ph == 2'd3 && m_inh == 0) begin
               if (!s_pre) s_inc = 1;
               else begin
                  if (((m_pcnt + 1) % (2 ** (s_r + 1))) == 0) s_inc = 1;
                  s_npc = (m_pcnt + 1) % 256;
               end
            end
         end else begin
            if (s_pre && s_src == 1 && m_rawd == 0) s_npc = (m_pcnt + 1) % 256;
            s_inc = (m_tick == 1 && m_inh == 0);
         end
         s_path = s_pre ? ((m_pcnt >> s_r) & 1) : s_src;
         if (ph == 2'd1 || ph == 2'd3) begin
            s_ntick = (s_path == 1 && m_samp == 0);
            s_nsamp = s_path;
         end
         m_samp = s_nsamp; m_tick = s_ntick; m_rawd = s_src;
         if (ph == 2'd3 && m_inh > 0) m_inh = m_inh - 1;
         m_ovf = 0;
         if (wr_en) begin
            m_cnt = wr_data; m_valid = 1'b1; s_npc = 0; m_inh = 2;
         end else if (s_inc != 0) begin
            m_ovf = (m_cnt == 255);
            m_cnt = (m_cnt + 1) % 256;
         end
         if (opt_we) begin
            m_opt = opt_wd; s_npc = 0;
         end
         m_pcnt = s_npc;
      end
   end

   task automatic chk(string req, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // per-clock comparison against the reference (R1 R3 R5 R9)
   always @(negedge clk) begin
      if (rst_n) begin
         if (m_valid) chk("R3/R5 model counter", cnt, m_cnt);
         chk("R9 model overflow", ovf, m_ovf);
      end
   end

   task automatic step(int n = 1);
      repeat (n) begin
         @(negedge clk);
         ph = ph + 2'd1;
         wr_en = 1'b0;
         opt_we = 1'b0;
      end
   endtask

   task automatic write_cnt(logic [7:0] v);
      step();
      while (ph != 2'd3) step();
      wr_en = 1'b1; wr_data = v;
      step();
   endtask

   task automatic set_opt(logic [5:0] v);
      step();
      opt_we = 1'b1; opt_wd = v;
      step();
   endtask

   task automatic narrow_pulse();
      step();
      while (ph[0] != 1'b0) step();
      pin = ~pin;
      step();
      pin = ~pin;
      step(3);
   endtask

   initial begin : watchdog
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      int ovc;
      rst_n = 1'b0; ph = 2'd0; wr_en = 1'b0; wr_data = '0; opt_we = 1'b0; opt_wd = '0;
      pin = 1'b1; cmp = 1'b1; csel = 1'b0;
      step(3);
      chk("R10 reset forces pin input", force_in, 1);
      chk("R10 reset overflow low", ovf, 0);
      rst_n = 1'b1;
      step(2);

      // internal, no prescaler
      set_opt(6'h08);
      chk("R11 internal source releases pin", force_in, 0);
      write_cnt(8'h20);
      chk("R1 written value", cnt, 8'h20);
      step(11);
      chk("R2 held after write", cnt, 8'h20);
      step();
      chk("R2 resumes at third Q4", cnt, 8'h21);
      step(4);
      chk("R3 one per instruction cycle", cnt, 8'h22);

      // internal, 1:2
      set_opt(6'h00);
      write_cnt(8'h40);
      step(15);
      chk("R4 1:2 before first advance", cnt, 8'h40);
      step();
      chk("R4 1:2 first advance", cnt, 8'h41);
      step(8);
      chk("R4 1:2 second advance", cnt, 8'h42);

      // every ratio
      for (int k = 0; k < 8; k++) begin
         int nr;
         nr = 2 ** (k + 1);
         set_opt(6'(k));
         write_cnt(8'h00);
         step(4 * (2 + 3 * nr) - 1);
         chk($sformatf("R4 ratio %0d before third advance", nr), cnt, 2);
         step();
         chk($sformatf("R4 ratio %0d third advance", nr), cnt, 3);
      end

      // wrap
      set_opt(6'h08);
      write_cnt(8'hFD);
      ovc = 0;
      for (int i = 0; i < 30; i++) begin
         step();
         if (ovf) begin
            ovc++;
            chk("R9 counter zero with pulse", cnt, 0);
         end
      end
      chk("R9 single overflow pulse", ovc, 1);
      write_cnt(8'hFF);
      write_cnt(8'h00);
      ovc = 0;
      for (int i = 0; i < 6; i++) begin
         step();
         if (ovf) ovc++;
      end
      chk("R9 write never overflows", ovc, 0);

      // external pin, rising, no prescaler
      pin = 1'b0;
      set_opt(6'h28);
      write_cnt(8'h10);
      step(12);
      for (int i = 0; i < 4; i++) narrow_pulse();
      chk("R5 narrow pulses ignored", cnt, 8'h10);
      for (int i = 0; i < 3; i++) begin
         pin = 1'b1; step(2); pin = 1'b0; step(2);
      end
      step(3);
      chk("R5 wide pulses counted", cnt, 8'h13);

      // comparator, falling edge
      csel = 1'b1; cmp = 1'b1;
      set_opt(6'h38);
      write_cnt(8'h30);
      step(12);
      for (int i = 0; i < 3; i++) begin
         pin = 1'b1; step(2); pin = 1'b0; step(2);
      end
      chk("R7 pin ignored with comparator selected", cnt, 8'h30);
      for (int i = 0; i < 2; i++) begin
         cmp = 1'b0; step(2); cmp = 1'b1; step(2);
      end
      step(3);
      chk("R6 falling edges counted", cnt, 8'h32);

      // external with prescaler
      csel = 1'b0; pin = 1'b0;
      set_opt(6'h20);
      write_cnt(8'h50);
      step(12);
      for (int i = 0; i < 8; i++) begin
         pin = 1'b1; step(); pin = 1'b0; step();
      end
      step(6);
      chk("R8 1:2 fast input", cnt, 8'h54);
      set_opt(6'h21);
      write_cnt(8'h60);
      step(12);
      for (int i = 0; i < 8; i++) begin
         pin = 1'b1; step(); pin = 1'b0; step();
      end
      step(6);
      chk("R8 1:4 fast input", cnt, 8'h62);

      // reset keeps the counter
      pin = 1'b1;
      write_cnt(8'h5A);
      step(2);
      rst_n = 1'b0;
      step(3);
      chk("R10 counter kept in reset", cnt, 8'h5A);
      chk("R10 option back to external", force_in, 1);
      rst_n = 1'b1;
      step(8);
      chk("R10 counter kept after reset", cnt, 8'h5A);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule